// File: doc/BRIEF.md
# Message Word Packer with Endian Reversal

This block sits between a simple 32-bit peripheral write port and a hash engine that consumes whole 32-bit message words. A producer may deliver data as single bytes, halfwords or full words. Sub-word pieces are gathered into one word in little-endian order. When the word is complete, its byte order may be reversed so that the first byte written becomes the most significant byte. The word is then handed downstream with a one-cycle valid strobe.

Packing in little-endian order and then reversing gives the same engine input for a byte buffer, whatever transfer size moved it. The block also raises a sticky error flag when a write arrives while the downstream engine is not ready. Such a write is discarded. A start pulse drops any partly gathered word, ready for a fresh message.

Top module: `msg_word_packer`

## Requirements
- R1: A write with `wr_size` = 2 (word) or 3 (treated as word) accepted while `eng_ready` is high produces `word_valid` high in the next cycle, with `word_out` equal to `wr_data` when reversal is off.
- R2: Halfword writes (`wr_size` = 1) take `wr_data[15:0]`. The first lands in bits 15:0 and the second in bits 31:16. The word is presented only after the second write.
- R3: Byte writes (`wr_size` = 0) take `wr_data[7:0]` and ignore the upper bits. The first byte lands in bits 7:0, and each following byte goes one lane higher. The word is presented only after the fourth byte.
- R4: With reversal on, the completed word is byte-reversed before it is presented: bytes b0..b3 written in that order give `word_out` = {b0,b1,b2,b3}, with b0 in bits 31:24.
- R5: Reversal is on after reset. A cycle with `swap_we` high loads `swap_val` as the new setting, which applies to words completed in later cycles.
- R6: A write while `eng_ready` is low sets `err_flag` in the next cycle. The flag stays set until a cycle with `err_clr` high and no new offending write. A new offending write wins over a clear in the same cycle.
- R7: A write while `eng_ready` is low is dropped: it produces no `word_valid` and leaves the partial word and lane position unchanged.
- R8: A `start` pulse discards any partial word and resets the lane position to zero. A write in the same cycle as `start` is ignored.
- R9: `word_valid` is high for exactly one cycle per completed word, and `word_out` holds its value until the next completed word.
- R10: After reset, `word_valid` and `err_flag` are low and `word_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| wr_data | input | 32 | Write data, right-aligned for sub-word sizes |
| start | input | 1 | Begin a new message; clears the partial word |
| swap_we | input | 1 | Load the reversal setting |
| swap_val | input | 1 | New reversal setting |
| err_clr | input | 1 | Clear the not-ready error flag |
| eng_ready | input | 1 | Downstream engine can take data |
| word_out | output | 32 | Last completed message word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| err_flag | output | 1 | Sticky write-while-not-ready flag |

## Verification
The packer is driven with single word writes, pairs of halfwords and runs of four bytes. The bytes carry junk in their upper bits and distinct values per lane, so a wrong lane order, a duplicated lane or a leak of upper bits each gives a different word. The same byte run is repeated with reversal on and off, which separates the swap from the packing order. Dropped writes in the middle of a partial word, and start pulses in the middle of a partial word, show whether the lane position survives or is reset. A clear that coincides with a new offending write checks the priority of the error flag.

// File: rtl/msg_pack_pkg.sv
package msg_pack_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } wr_size_e;
endpackage

// File: rtl/msg_lane_merge.sv
module msg_lane_merge
    import msg_pack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int CNT_W = $clog2(LANES) + 1
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] merged,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              done
);
    localparam int HALF_LANES = 2;

    int base;
    int nlanes;
    int total;

    always_comb begin
        case (wr_size_e'(size))
            SZ_BYTE: begin base = int'(cnt); nlanes = 1;          end
            SZ_HALF: begin base = int'(cnt); nlanes = HALF_LANES; end
            default: begin base = 0;         nlanes = LANES;      end
        endcase
        merged = acc;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if ((j < nlanes) && (base + j == i))
                    merged[i*BYTE_W +: BYTE_W] = data[j*BYTE_W +: BYTE_W];
            end
        end
        total    = base + nlanes;
        done     = (total >= LANES);
        cnt_next = done ? '0 : CNT_W'(total);
    end
endmodule

// File: rtl/msg_byte_reverse.sv
module msg_byte_reverse #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*BYTE_W +: BYTE_W] = din[(LANES-1-g)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/msg_word_packer.sv
module msg_word_packer
    import msg_pack_pkg::*;
#(
    parameter int   DATA_W     = 32,
    parameter int   BYTE_W     = 8,
    parameter logic SWAP_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic              swap_we,
    input  logic              swap_val,
    input  logic              err_clr,
    input  logic              eng_ready,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid,
    output logic              err_flag
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int CNT_W = $clog2(LANES) + 1;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] out;
        logic              vld;
        logic              err;
        logic              swap;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] merged_w;
    logic [DATA_W-1:0] reversed_w;
    logic [CNT_W-1:0]  cnt_next_w;
    logic              done_w;
    logic              accept;
    logic              swap_on;

    msg_lane_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
        .acc      (st_q.acc),
        .cnt      (st_q.cnt),
        .size     (wr_size),
        .data     (wr_data),
        .merged   (merged_w),
        .cnt_next (cnt_next_w),
        .done     (done_w)
    );

    msg_byte_reverse #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rev (
        .din  (merged_w),
        .dout (reversed_w)
    );

    assign accept = wr_en && eng_ready && !start;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (accept) begin
            if (done_w) begin
                st_d.out = st_q.swap ? reversed_w : merged_w;
                st_d.vld = 1'b1;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = merged_w;
                st_d.cnt = cnt_next_w;
            end
        end
        if (wr_en && !eng_ready)
            st_d.err = 1'b1;
        else if (err_clr)
            st_d.err = 1'b0;
        if (swap_we)
            st_d.swap = swap_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.swap <= SWAP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out   = st_q.out;
    assign word_valid = st_q.vld;
    assign err_flag   = st_q.err;
    assign swap_on    = st_q.swap;
endmodule

// File: rtl/msg_word_packer_chk.sv
module msg_word_packer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_size,
    input logic [DATA_W-1:0] wr_data,
    input logic              start,
    input logic              swap_we,
    input logic              err_clr,
    input logic              eng_ready,
    input logic              swap_on,
    input logic [DATA_W-1:0] word_out,
    input logic              word_valid,
    input logic              err_flag
);
    // R1
    word_write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eng_ready && !start && wr_size[1]) |=> word_valid);

    // R1
    word_write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eng_ready && !start && wr_size[1] && !swap_on && !swap_we)
        |=> (word_out == $past(wr_data)));

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !eng_ready) |=> err_flag);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(wr_en && !eng_ready)) |=> !err_flag);

    // R7
    dropped_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !eng_ready) |=> !word_valid);

    // R8
    start_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !word_valid);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));
endmodule

bind msg_word_packer msg_word_packer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .start      (start),
    .swap_we    (swap_we),
    .err_clr    (err_clr),
    .eng_ready  (eng_ready),
    .swap_on    (swap_on),
    .word_out   (word_out),
    .word_valid (word_valid),
    .err_flag   (err_flag)
);

// File: tb/tb_msg_word_packer.sv
module tb_msg_word_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        swap_we = 1'b0;
    logic        swap_val = 1'b0;
    logic        err_clr = 1'b0;
    logic        eng_ready = 1'b1;
    logic [31:0] word_out;
    logic        word_valid;
    logic        err_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msg_word_packer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
        .wr_data(wr_data), .start(start), .swap_we(swap_we),
        .swap_val(swap_val), .err_clr(err_clr), .eng_ready(eng_ready),
        .word_out(word_out), .word_valid(word_valid), .err_flag(err_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge after the registering edge.
    task automatic wr(input logic [1:0] sz, input logic [31:0] d);
        wr_en = 1'b1; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic set_swap(input logic v);
        swap_we = 1'b1; swap_val = v;
        @(negedge clk);
        swap_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 valid", {31'd0, word_valid}, 32'd0);
        check("R10 err", {31'd0, err_flag}, 32'd0);
        check("R10 word", word_out, 32'd0);
    endtask

    task automatic t_swap_default();
        // R5: reversal on after reset
        wr(2'd0, 32'hFFFF_FF11); wr(2'd0, 32'h0000_0022);
        wr(2'd0, 32'hABCD_EF33); wr(2'd0, 32'h1234_5644);
        check("R5 default reversal", word_out, 32'h1122_3344);
        check("R4 valid", {31'd0, word_valid}, 32'd1);
    endtask

    task automatic t_word();
        set_swap(1'b0);
        wr(2'd2, 32'hDEAD_BEEF);
        check("R1 valid", {31'd0, word_valid}, 32'd1);
        check("R1 data", word_out, 32'hDEAD_BEEF);
        idle();
        check("R9 single cycle", {31'd0, word_valid}, 32'd0);
        check("R9 hold", word_out, 32'hDEAD_BEEF);
        wr(2'd3, 32'h0102_0304);
        check("R1 size 3 as word", word_out, 32'h0102_0304);
    endtask

    task automatic t_half();
        wr(2'd1, 32'h9999_A1B2);
        check("R2 no valid after first half", {31'd0, word_valid}, 32'd0);
        wr(2'd1, 32'h7777_C3D4);
        check("R2 valid", {31'd0, word_valid}, 32'd1);
        check("R2 packing", word_out, 32'hC3D4_A1B2);
    endtask

    task automatic t_byte();
        wr(2'd0, 32'hFFFF_FF11);
        wr(2'd0, 32'hEEEE_EE22);
        wr(2'd0, 32'hDDDD_DD33);
        check("R3 no valid before fourth", {31'd0, word_valid}, 32'd0);
        wr(2'd0, 32'hCCCC_CC44);
        check("R3 valid", {31'd0, word_valid}, 32'd1);
        check("R3 packing", word_out, 32'h4433_2211);
    endtask

    task automatic t_swap_on();
        set_swap(1'b1);
        wr(2'd0, 32'h0000_00A0); wr(2'd0, 32'h0000_00B1);
        wr(2'd0, 32'h0000_00C2); wr(2'd0, 32'h0000_00D3);
        check("R4 reversed bytes", word_out, 32'hA0B1_C2D3);
        wr(2'd1, 32'h0000_1234); wr(2'd1, 32'h0000_5678);
        check("R4 reversed halves", word_out, 32'h3412_7856);
        set_swap(1'b0);
        wr(2'd2, 32'h1122_3344);
        check("R5 reversal off", word_out, 32'h1122_3344);
    endtask

    task automatic t_notready();
        wr(2'd0, 32'h0000_0001);
        eng_ready = 1'b0;
        wr(2'd0, 32'h0000_00EE);
        check("R7 dropped no valid", {31'd0, word_valid}, 32'd0);
        check("R6 err set", {31'd0, err_flag}, 32'd1);
        eng_ready = 1'b1;
        idle(); idle();
        check("R6 err sticky", {31'd0, err_flag}, 32'd1);
        wr(2'd0, 32'h0000_0002); wr(2'd0, 32'h0000_0003); wr(2'd0, 32'h0000_0004);
        check("R7 partial kept", word_out, 32'h0403_0201);
        // clear together with new offending write: set wins
        eng_ready = 1'b0; err_clr = 1'b1;
        wr(2'd2, 32'h5555_5555);
        err_clr = 1'b0; eng_ready = 1'b1;
        check("R6 set beats clear", {31'd0, err_flag}, 32'd1);
        check("R7 no word from dropped", word_out, 32'h0403_0201);
        err_clr = 1'b1; idle(); err_clr = 1'b0;
        check("R6 cleared", {31'd0, err_flag}, 32'd0);
    endtask

    task automatic t_start();
        wr(2'd0, 32'h0000_0077); wr(2'd0, 32'h0000_0066);
        pulse_start();
        wr(2'd0, 32'h0000_0010); wr(2'd0, 32'h0000_0020);
        wr(2'd0, 32'h0000_0030);
        check("R8 counter reset", {31'd0, word_valid}, 32'd0);
        wr(2'd0, 32'h0000_0040);
        check("R8 fresh word", word_out, 32'h4030_2010);
        // write together with start is ignored
        wr(2'd1, 32'h0000_AAAA);
        start = 1'b1;
        wr(2'd2, 32'hBBBB_BBBB);
        start = 1'b0;
        check("R8 write at start ignored", {31'd0, word_valid}, 32'd0);
        wr(2'd1, 32'h0000_1111); wr(2'd1, 32'h0000_2222);
        check("R8 after start", word_out, 32'h2222_1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swap_default();
        t_word();
        t_half();
        t_byte();
        t_swap_on();
        t_notready();
        t_start();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule